// File: doc/BRIEF.md
# PS/2 Two-Port Command Transmitter

This block sends one command byte from the host to one of two PS/2 devices. Port 0 is the keyboard and port 1 is the mouse. Each line is open-collector: the block drives a line low through a pull-low output and reads the real level back on an input.

A transfer starts when the start strobe is raised while the block is idle. The block first pulls both clock lines low to stop both devices. It then holds them that way for a programmable number of system cycles. After that it lets go of the selected device's clock and pulls that device's data line low as the start bit. The other device's clock stays low until the transfer has ended.

From then on the selected device supplies the clock. The block samples its clock and data through synchronisers and changes the bit it drives only after a falling edge. On the final pulse it looks for the device's acknowledge. The transfer ends with a one-cycle done pulse, or with a one-cycle error pulse on a timeout or a missing acknowledge. In both cases every line is released.

Top module: `ps2_cmd_tx`

## Requirements
- R1: While idle, a high `tx_go` latches `tx_port` and `tx_byte`. In the next cycle `busy` is high and both clock pull-low outputs are asserted.
- R2: While `busy` is high, the clock pull-low of the port not selected stays asserted in every cycle. Whenever `busy` is low, all four pull-low outputs are deasserted.
- R3: Both clocks are held low for exactly `INHIBIT_CYC` cycles. In the cycle where the selected clock is released, the selected data line is pulled low as the start bit.
- R4: After device clock falls 1 to 8, the block presents data bits 0 to 7 in that order, least significant bit first. A 0 bit means data is pulled low and a 1 bit means data is released. After fall 9 it presents odd parity, so the ones in the byte plus the parity bit add up to an odd count. After fall 10 it releases data as the stop bit. The data pull-low never changes while the selected clock line stays high.
- R5: If the selected data line is seen low during the 11th clock pulse, `done` pulses for one cycle once both selected lines are high again. `busy` drops in that same cycle and `err` stays low.
- R6: If the data line is still high when the 11th pulse ends, `err` pulses for one cycle shortly after that rising edge. `done` does not pulse and all lines are released.
- R7: After the selected clock is released, if `TIMEOUT_CYC` cycles go by without a clock edge from the device, `err` pulses for one cycle and all lines are released. This applies before the first pulse and also mid-frame.
- R8: A `tx_go` raised while `busy` is high has no effect. The frame in progress keeps its byte and port, and no second transfer follows it.
- R9: In and right after reset, `busy`, `done` and `err` are low and no line is pulled low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tx_go | input | 1 | Start strobe, sampled only while idle |
| tx_port | input | 1 | Destination: 0 keyboard port, 1 mouse port |
| tx_byte | input | 8 | Command byte to send |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle pulse: frame acknowledged |
| err | output | 1 | One-cycle pulse: timeout or missing acknowledge |
| ps2_clk_i | input | 2 | Sensed clock line level, one bit per port |
| ps2_dat_i | input | 2 | Sensed data line level, one bit per port |
| ps2_clk_lo_o | output | 2 | Pull clock line low, one bit per port |
| ps2_dat_lo_o | output | 2 | Pull data line low, one bit per port |

## Verification
The bench builds the block with `INHIBIT_CYC` = 20, `TIMEOUT_CYC` = 300 and two synchroniser stages. With these values a full frame takes only a few hundred cycles, so every one of the 256 byte values can be sent. The destination port alternates across the sweep. The small values also make the exact inhibit length and the timeout latency measurable cycle by cycle. This covers three failure cases: a device that never clocks, one that stops after five pulses, and one that withholds the acknowledge. Each runs well within the run limit.

// File: rtl/ps2tx_pkg.sv
package ps2tx_pkg;

    localparam int unsigned NPORT       = 2;
    localparam int unsigned FRAME_BITS  = 10;  // 8 data, parity, stop
    localparam int unsigned FRAME_FALLS = 11;  // device pulses per frame

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_INHIBIT,
        ST_SHIFT,
        ST_ACK,
        ST_DRAIN
    } tx_state_e;

    typedef struct packed {
        tx_state_e              st;
        logic                   tgt;
        logic [FRAME_BITS-1:0]  sh;
        logic [3:0]             nfall;
        logic                   ack;
        logic [NPORT-1:0]       clk_lo;
        logic [NPORT-1:0]       dat_lo;
        logic                   busy;
        logic                   done;
        logic                   err;
    } tx_regs_t;

    localparam tx_regs_t TX_REGS_RST = '{
        st:     ST_IDLE,
        tgt:    1'b0,
        sh:     '0,
        nfall:  '0,
        ack:    1'b0,
        clk_lo: '0,
        dat_lo: '0,
        busy:   1'b0,
        done:   1'b0,
        err:    1'b0
    };

    // odd parity: the returned bit makes the total count of ones odd
    function automatic logic odd_par(input logic [7:0] b);
        return ~^b;
    endfunction

endpackage

// File: rtl/ps2tx_sync.sv
module ps2tx_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] ff_d, ff_q;

    always_comb begin
        ff_d = {ff_q[STAGES-2:0], din};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ff_q <= '1;   // idle bus level is high
        else        ff_q <= ff_d;
    end

    assign dout = ff_q[STAGES-1];
endmodule

// File: rtl/ps2tx_edge.sv
module ps2tx_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl,
    output logic fall,
    output logic rise
);
    logic prev_d, prev_q;

    always_comb begin
        prev_d = lvl;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b1;
        else        prev_q <= prev_d;
    end

    assign fall = prev_q & ~lvl;
    assign rise = ~prev_q & lvl;
endmodule

// File: rtl/ps2tx_timer.sv
module ps2tx_timer #(
    parameter int unsigned LIMIT = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic en,
    output logic expired
);
    localparam int unsigned CW = $clog2(LIMIT) + 1;

    logic [CW-1:0] cnt_d, cnt_q;

    assign expired = en && (cnt_q == CW'(LIMIT - 1));

    always_comb begin
        cnt_d = cnt_q;
        if (clr)                cnt_d = '0;
        else if (en && !expired) cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/ps2_cmd_tx.sv
module ps2_cmd_tx
    import ps2tx_pkg::*;
#(
    parameter int unsigned INHIBIT_CYC = 10000,
    parameter int unsigned TIMEOUT_CYC = 1500000,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tx_go,
    input  logic       tx_port,
    input  logic [7:0] tx_byte,
    output logic       busy,
    output logic       done,
    output logic       err,
    input  logic [1:0] ps2_clk_i,
    input  logic [1:0] ps2_dat_i,
    output logic [1:0] ps2_clk_lo_o,
    output logic [1:0] ps2_dat_lo_o
);
    localparam logic [3:0] LAST_FALL = 4'(FRAME_FALLS - 1);

    tx_regs_t r_d, r_q;

    // line conditioning, one pair of synchronisers per port
    logic [NPORT-1:0] s_clk, s_dat;

    for (genvar p = 0; p < NPORT; p++) begin : g_port
        ps2tx_sync #(.STAGES(SYNC_STAGES)) u_sclk (
            .clk(clk), .rst_n(rst_n), .din(ps2_clk_i[p]), .dout(s_clk[p])
        );
        ps2tx_sync #(.STAGES(SYNC_STAGES)) u_sdat (
            .clk(clk), .rst_n(rst_n), .din(ps2_dat_i[p]), .dout(s_dat[p])
        );
    end

    logic t_clk, t_dat, t_fall, t_rise;
    assign t_clk = s_clk[r_q.tgt];
    assign t_dat = s_dat[r_q.tgt];

    ps2tx_edge u_edge (
        .clk(clk), .rst_n(rst_n), .lvl(t_clk), .fall(t_fall), .rise(t_rise)
    );

    // inhibit period
    logic inh_clr, inh_exp;
    assign inh_clr = (r_q.st != ST_INHIBIT);

    ps2tx_timer #(.LIMIT(INHIBIT_CYC)) u_inh_tmr (
        .clk(clk), .rst_n(rst_n), .clr(inh_clr), .en(!inh_clr), .expired(inh_exp)
    );

    // device silence watchdog, restarted on every selected clock edge
    logic wd_active, wd_clr, wd_exp;
    assign wd_active = (r_q.st == ST_SHIFT) || (r_q.st == ST_ACK) || (r_q.st == ST_DRAIN);
    assign wd_clr    = !wd_active || t_fall || t_rise;

    ps2tx_timer #(.LIMIT(TIMEOUT_CYC)) u_wd_tmr (
        .clk(clk), .rst_n(rst_n), .clr(wd_clr), .en(!wd_clr), .expired(wd_exp)
    );

    logic abort_v, finish_v;

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        r_d.err  = 1'b0;
        abort_v  = 1'b0;
        finish_v = 1'b0;

        case (r_q.st)
            ST_IDLE: begin
                if (tx_go) begin
                    r_d.st     = ST_INHIBIT;
                    r_d.tgt    = tx_port;
                    r_d.sh     = {1'b1, odd_par(tx_byte), tx_byte};
                    r_d.nfall  = '0;
                    r_d.ack    = 1'b0;
                    r_d.busy   = 1'b1;
                    r_d.clk_lo = '1;
                    r_d.dat_lo = '0;
                end
            end

            ST_INHIBIT: begin
                if (inh_exp) begin
                    r_d.st               = ST_SHIFT;
                    r_d.clk_lo[r_q.tgt]  = 1'b0;
                    r_d.dat_lo[r_q.tgt]  = 1'b1;   // start bit
                end
            end

            ST_SHIFT: begin
                if (wd_exp) begin
                    abort_v = 1'b1;
                end else if (t_fall) begin
                    r_d.nfall = r_q.nfall + 4'd1;
                    if (r_q.nfall == LAST_FALL) begin
                        r_d.st = ST_ACK;
                    end else begin
                        r_d.dat_lo[r_q.tgt] = ~r_q.sh[0];
                        r_d.sh              = {1'b1, r_q.sh[FRAME_BITS-1:1]};
                    end
                end
            end

            ST_ACK: begin
                if (!t_dat) r_d.ack = 1'b1;
                if (wd_exp) begin
                    abort_v = 1'b1;
                end else if (t_rise) begin
                    if (r_q.ack || !t_dat) r_d.st = ST_DRAIN;
                    else                   abort_v = 1'b1;
                end
            end

            ST_DRAIN: begin
                if (wd_exp)              abort_v  = 1'b1;
                else if (t_clk && t_dat) finish_v = 1'b1;
            end

            default: r_d.st = ST_IDLE;
        endcase

        if (abort_v || finish_v) begin
            r_d.st     = ST_IDLE;
            r_d.busy   = 1'b0;
            r_d.clk_lo = '0;
            r_d.dat_lo = '0;
            r_d.err    = abort_v;
            r_d.done   = finish_v;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= TX_REGS_RST;
        else        r_q <= r_d;
    end

    assign busy         = r_q.busy;
    assign done         = r_q.done;
    assign err          = r_q.err;
    assign ps2_clk_lo_o = r_q.clk_lo;
    assign ps2_dat_lo_o = r_q.dat_lo;

endmodule

// File: rtl/ps2_cmd_tx_chk.sv
module ps2_cmd_tx_chk #(
    parameter int unsigned INHIBIT_CYC = 10000
) (
    input logic       clk,
    input logic       rst_n,
    input logic       tx_go,
    input logic       tx_port,
    input logic       busy,
    input logic       done,
    input logic       err,
    input logic [1:0] ps2_clk_i,
    input logic [1:0] ps2_dat_i,
    input logic [1:0] ps2_clk_lo_o,
    input logic [1:0] ps2_dat_lo_o
);
    logic        tgt_q;
    logic [31:0] inh_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)             tgt_q <= 1'b0;
        else if (tx_go && !busy) tgt_q <= tx_port;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                          inh_cnt <= '0;
        else if (!busy)                                      inh_cnt <= '0;
        else if (ps2_clk_lo_o == 2'b11 && inh_cnt != '1)     inh_cnt <= inh_cnt + 1;
    end

    AST_START_BOTH_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> ps2_clk_lo_o == 2'b11);                                   // R1

    AST_OTHER_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> ps2_clk_lo_o[~tgt_q]);                                           // R2

    AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (ps2_clk_lo_o == 2'b00 && ps2_dat_lo_o == 2'b00));              // R2

    AST_INHIBIT_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $fell(ps2_clk_lo_o[tgt_q])) |-> inh_cnt >= INHIBIT_CYC);       // R3

    AST_START_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $fell(ps2_clk_lo_o[tgt_q])) |-> ps2_dat_lo_o[tgt_q]);          // R3

    AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy) && ps2_clk_i[tgt_q] && $past(ps2_clk_i[tgt_q]))
            |-> $stable(ps2_dat_lo_o));                                           // R4

    AST_DONE_LINES_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (ps2_clk_i[tgt_q] && ps2_dat_i[tgt_q]));                        // R5

    AST_DONE_ERR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && err));                                                          // R6

    AST_END_DROPS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (done || err) |-> (!busy && $past(busy)));                                // R7

endmodule

bind ps2_cmd_tx ps2_cmd_tx_chk #(.INHIBIT_CYC(INHIBIT_CYC)) u_chk (
    .clk(clk), .rst_n(rst_n), .tx_go(tx_go), .tx_port(tx_port),
    .busy(busy), .done(done), .err(err),
    .ps2_clk_i(ps2_clk_i), .ps2_dat_i(ps2_dat_i),
    .ps2_clk_lo_o(ps2_clk_lo_o), .ps2_dat_lo_o(ps2_dat_lo_o)
);

// File: tb/ps2_cmd_tx_bench.sv
module ps2_cmd_tx_bench;
    localparam int INH = 20;
    localparam int TMO = 300;
    localparam int HP  = 12;   // device half period in system cycles

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic       go = 1'b0;
    logic       port = 1'b0;
    logic [7:0] txb = '0;
    logic       busy, done, err;
    logic [1:0] hclk_lo, hdat_lo;
    logic [1:0] dclk_lo = '0;
    logic [1:0] ddat_lo = '0;
    wire  [1:0] clk_line = ~(hclk_lo | dclk_lo);
    wire  [1:0] dat_line = ~(hdat_lo | ddat_lo);

    ps2_cmd_tx #(.INHIBIT_CYC(INH), .TIMEOUT_CYC(TMO), .SYNC_STAGES(2)) u_ps2_cmd_tx (
        .clk(clk), .rst_n(rst_n), .tx_go(go), .tx_port(port), .tx_byte(txb),
        .busy(busy), .done(done), .err(err),
        .ps2_clk_i(clk_line), .ps2_dat_i(dat_line),
        .ps2_clk_lo_o(hclk_lo), .ps2_dat_lo_o(hdat_lo)
    );

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    // device side model: waits for release and start bit, then clocks
    task automatic run_dev(input bit p, input int npulses, input bit ack,
                           output logic [10:0] smp);
        smp = '0;
        do @(negedge clk); while (!(clk_line[p] && !dat_line[p]));
        wait_cyc(20);
        for (int k = 1; k <= npulses; k++) begin
            dclk_lo[p] = 1'b1;
            wait_cyc(HP / 2);
            if (k == 11 && ack) ddat_lo[p] = 1'b1;
            wait_cyc(HP - HP / 2);
            dclk_lo[p] = 1'b0;
            smp[k-1] = dat_line[p];
            wait_cyc(2);
            if (k == 11) ddat_lo[p] = 1'b0;
            wait_cyc(HP - 2);
        end
    endtask

    typedef struct {
        logic [10:0] smp;
        int ndone, nerr, inh, hold_viol, other_viol, lines_bad, rel_at, err_at;
        bit start_ok;
        bit r1_ok;
    } xres_t;

    task automatic xfer(input bit p, input logic [7:0] b, input int npulses,
                        input bit ack, input bit inject, output xres_t res);
        res = '{smp: '0, ndone: 0, nerr: 0, inh: 0, hold_viol: 0, other_viol: 0,
                lines_bad: 0, rel_at: -1, err_at: -1, start_ok: 1'b0, r1_ok: 1'b0};
        @(negedge clk);
        go = 1'b1; port = p; txb = b;
        fork
            begin
                @(negedge clk);
                go = 1'b0;
                res.r1_ok = busy && (hclk_lo == 2'b11);
                if (inject) begin
                    wait_cyc(120);
                    go = 1'b1; port = ~p; txb = ~b;
                    @(negedge clk);
                    go = 1'b0;
                end
            end
            begin
                logic [10:0] s;
                run_dev(p, npulses, ack, s);
                res.smp = s;
            end
            begin
                int  cyc  = 0;
                bit  seen = 1'b0;
                logic pclk = 1'b0, pdat = 1'b0, phlo = 1'b0;
                while (cyc < 4000) begin
                    @(negedge clk);
                    cyc++;
                    if (busy) seen = 1'b1;
                    if (busy && hclk_lo == 2'b11) res.inh++;
                    if (busy && !hclk_lo[~p]) res.other_viol++;
                    if (busy && phlo && !hclk_lo[p]) begin
                        res.start_ok = hdat_lo[p];
                        res.rel_at   = cyc;
                    end
                    if (busy && pclk && clk_line[p] && hdat_lo[p] != pdat) res.hold_viol++;
                    if (done) begin
                        res.ndone++;
                        if (!(clk_line[p] && dat_line[p])) res.lines_bad++;
                    end
                    if (err) begin
                        res.nerr++;
                        res.err_at = cyc;
                    end
                    pclk = clk_line[p];
                    pdat = hdat_lo[p];
                    phlo = hclk_lo[p];
                    if (seen && !busy) break;
                end
            end
        join
    endtask

    task automatic check_good(input bit p, input logic [7:0] b, input xres_t r);
        chk(r.r1_ok, "R1", "busy and both clocks low after go", int'(r.r1_ok), 1);
        chk(r.smp[7:0] == b, "R4", "data bits lsb first", int'(r.smp[7:0]), int'(b));
        chk(r.smp[8] == ~^b, "R4", "odd parity bit", int'(r.smp[8]), int'(~^b));
        chk(r.smp[9] == 1'b1, "R4", "stop bit released", int'(r.smp[9]), 1);
        chk(r.hold_viol == 0, "R4", "data change while clock high", r.hold_viol, 0);
        chk(r.inh == INH, "R3", "inhibit length", r.inh, INH);
        chk(r.start_ok, "R3", "start bit at release", int'(r.start_ok), 1);
        chk(r.other_viol == 0, "R2", "other clock released early", r.other_viol, 0);
        chk(r.ndone == 1 && r.nerr == 0, "R5", "done count", r.ndone, 1);
        chk(r.lines_bad == 0, "R5", "lines high at done", r.lines_bad, 0);
        chk(hclk_lo == 2'b00 && hdat_lo == 2'b00, "R2", "release after end",
            int'({hclk_lo, hdat_lo}), 0);
        if (p) begin end
    endtask

    initial begin
        xres_t r;
        bit    rebusy;

        wait_cyc(3);
        chk(!busy && !done && !err, "R9", "flags in reset", int'({busy, done, err}), 0);
        chk(hclk_lo == 2'b00 && hdat_lo == 2'b00, "R9", "drives in reset",
            int'({hclk_lo, hdat_lo}), 0);
        rst_n = 1'b1;
        wait_cyc(3);
        chk(!busy && !done && !err, "R9", "flags after reset", int'({busy, done, err}), 0);
        chk(hclk_lo == 2'b00 && hdat_lo == 2'b00, "R9", "drives after reset",
            int'({hclk_lo, hdat_lo}), 0);

        // R7: device never clocks
        xfer(1'b0, 8'h3C, 0, 1'b1, 1'b0, r);
        chk(r.nerr == 1 && r.ndone == 0, "R7", "silent device error", r.nerr, 1);
        chk(r.err_at - r.rel_at >= TMO && r.err_at - r.rel_at <= TMO + 8, "R7",
            "timeout latency", r.err_at - r.rel_at, TMO);
        chk(hclk_lo == 2'b00 && hdat_lo == 2'b00, "R7", "release after timeout",
            int'({hclk_lo, hdat_lo}), 0);

        // R7: device stalls mid-frame
        xfer(1'b1, 8'hC3, 5, 1'b1, 1'b0, r);
        chk(r.nerr == 1 && r.ndone == 0, "R7", "stalled device error", r.nerr, 1);
        chk(hclk_lo == 2'b00 && hdat_lo == 2'b00, "R7", "release after stall",
            int'({hclk_lo, hdat_lo}), 0);

        // R6: no acknowledge
        xfer(1'b1, 8'hA5, 11, 1'b0, 1'b0, r);
        chk(r.nerr == 1 && r.ndone == 0, "R6", "missing ack error", r.nerr, 1);
        chk(r.err_at - r.rel_at >= 20 + 21 * HP && r.err_at - r.rel_at <= 20 + 21 * HP + 8,
            "R6", "error after 11th rise", r.err_at - r.rel_at, 20 + 21 * HP);
        chk(hclk_lo == 2'b00 && hdat_lo == 2'b00, "R6", "release after nack",
            int'({hclk_lo, hdat_lo}), 0);

        // R8: strobe during a frame is ignored
        xfer(1'b0, 8'h96, 11, 1'b1, 1'b1, r);
        check_good(1'b0, 8'h96, r);
        rebusy = 1'b0;
        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            if (busy || hclk_lo != 2'b00) rebusy = 1'b1;
        end
        chk(!rebusy, "R8", "no second frame after ignored strobe", int'(rebusy), 0);
        chk(r.smp[7:0] == 8'h96, "R8", "frame kept its byte", int'(r.smp[7:0]), 8'h96);

        // sweep every byte value, alternating the destination port
        for (int i = 0; i < 256; i++) begin
            logic [7:0] b;
            bit p;
            b = 8'(i);
            p = b[0] ^ b[5];
            xfer(p, b, 11, 1'b1, 1'b0, r);
            check_good(p, b, r);
            wait_cyc(4);
        end

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule